// File: doc/BRIEF.md
# 64-bit Single-Error-Correct / Double-Error-Detect Codec

This block protects a 64-bit data word held in a memory array. On the write side it appends eight check bits, giving a 72-bit word to store. On the read side it takes the 72-bit word back, recomputes the check bits from the data half and compares them with the stored ones. The difference (the syndrome) and the parity of the whole word are used to locate a failing bit. A failing data bit is flipped. A double error, or any pattern the code cannot place, is reported as uncorrectable.

The code is an extended Hamming code. Seven Hamming check bits sit at the power-of-two positions 1, 2, 4, ..., 64 of a 71-position Hamming vector. The data bits fill the remaining positions 3, 5, 6, 7, 9, ... in ascending order. A final parity bit makes the whole 72-bit word even. The corrected data leaves through a register. The 3-bit status either comes from a register that shares the data register's clock and asynchronous clear, or it is combinational and reflects the word currently at the input. The parameter `REG_STATUS` selects between the two.

Top module: `secded_codec`

## Requirements
- R1: `encWord` is `{parity, check[6:0], data[63:0]}`. `check[j]` is the XOR of the data bits whose Hamming position has bit j set. Data bit k occupies the k-th non-power-of-two position counting from 3. `parity` makes the XOR of all 72 bits zero. `encWord` is combinational from `wrData`.
- R2: A read word equal to a valid encoding gives `outData` equal to its data half and status 3'b000.
- R3: A read word with exactly one flipped bit in positions 0..63 gives `outData` equal to the original data and status 3'b011.
- R4: A read word with exactly one flipped bit in positions 64..71 (check or parity bit) gives status 3'b011, and `outData` equals `rdWord[63:0]` unchanged.
- R5: A read word with exactly two flipped bits gives status 3'b101, and `outData` equals `rdWord[63:0]` unmodified.
- R6: The status is only ever 3'b000, 3'b011 or 3'b101. Bit 0 means an error was seen, bit 1 means it was corrected, and bit 2 means it could not be corrected.
- R7: `outData` follows `rdWord` one clock edge later. With `REG_STATUS`=1, the status is registered alongside the data. With `REG_STATUS`=0, the status is combinational from `rdWord` and has no clear.
- R8: Driving `rstN` low immediately clears `outData` and the registered status to zero, without waiting for a clock edge.
- R9: Odd overall parity with a syndrome above 71 (an address no single error can produce) gives status 3'b101, and `outData` equals `rdWord[63:0]` unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rstN | input | 1 | Asynchronous clear, active low |
| wrData | input | 64 | Data to be encoded |
| encWord | output | 72 | Encoded word to store |
| rdWord | input | 72 | Word read back from storage |
| outData | output | 64 | Corrected (or passed-through) data, registered |
| eccStatus | output | 3 | Status code: 000 clean, 011 corrected, 101 uncorrectable |

## Verification
The assertions take for granted that `rdWord` is a known value at every clock edge. They also take for granted that any error pattern is a whole set of flipped bits, with no X on the bus. The stimulus always builds `rdWord` as a correctly encoded word XOR a corruption mask with 0, 1, 2 or 3 bits set, and drives it only on the falling edge, so every sampled edge sees a settled, defined word. The three-bit masks are chosen only where the outcome is fixed by the code: an out-of-range syndrome. No unbounded higher-order patterns are applied, since the code gives no promise for them.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Width of the position field carried from control to datapath.
  localparam int PosW = 8;

  typedef enum logic [2:0] {
    ST_CLEAN = 3'b000,
    ST_FIXED = 3'b011,
    ST_UNFIX = 3'b101
  } eccStat_e;

  // Strobes from the locator to the correction datapath.
  typedef struct packed {
    logic            flipData;
    logic [PosW-1:0] flipPos;
  } fixCtl_t;

  // Number of Hamming check bits needed for dw data bits.
  function automatic int hamBits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Hamming position (1-based) assigned to data bit idx.
  function automatic int dataPos(int idx);
    int seen;
    int res;
    seen = 0;
    res  = 0;
    for (int p = 3; p < 1024; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx && res == 0) res = p;
        seen++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_dpath.sv
module secded_dpath
  import secded_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int HAM_W  = hamBits(DATA_W),
  localparam int CW_W   = DATA_W + HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CW_W-1:0]   encWord,
  input  logic [CW_W-1:0]   rdWord,
  input  fixCtl_t           fixCtl,
  output logic [HAM_W-1:0]  syndrome,
  output logic              parityOdd,
  output logic [DATA_W-1:0] outData
);

  // Data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] colMask(int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((dataPos(i) >> j) & 1) != 0;
    return m;
  endfunction

  logic [DATA_W-1:0] rdData;
  logic [HAM_W-1:0]  rdCheck;
  logic [HAM_W-1:0]  encCheck;
  logic [HAM_W-1:0]  reCheck;
  logic [DATA_W-1:0] flipMask;
  logic [DATA_W-1:0] corrData;

  assign rdData  = rdWord[DATA_W-1:0];
  assign rdCheck = rdWord[DATA_W +: HAM_W];

  // Encoder and re-encoder share the same column masks.
  for (genvar j = 0; j < HAM_W; j++) begin : g_chk
    localparam logic [DATA_W-1:0] ColM = colMask(j);
    assign encCheck[j] = ^(wrData & ColM);
    assign reCheck[j]  = ^(rdData & ColM);
  end

  assign encWord   = {^{encCheck, wrData}, encCheck, wrData};
  assign syndrome  = reCheck ^ rdCheck;
  assign parityOdd = ^rdWord;

  // Decode the located position into a one-hot flip mask.
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [PosW-1:0] MyPos = PosW'(dataPos(i));
    assign flipMask[i] = fixCtl.flipData && (fixCtl.flipPos == MyPos);
  end

  assign corrData = rdData ^ flipMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outData <= '0;
    else       outData <= corrData;
  end

  // R3: correction never touches more than one data bit.
  a_r3_one_bit_fix: assert property (@(posedge clk) disable iff (!rstN)
    $countones(corrData ^ rdData) <= 1);

  // R5: with no flip strobe the raw data reaches the output one edge later.
  a_r5_raw_pass: assert property (@(posedge clk) disable iff (!rstN)
    !fixCtl.flipData |=> outData == $past(rdData));

endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
#(
  parameter  int DATA_W     = 64,
  parameter  bit REG_STATUS = 1'b1,
  localparam int HAM_W      = hamBits(DATA_W),
  localparam int MAX_POS    = DATA_W + HAM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [HAM_W-1:0] syndrome,
  input  logic             parityOdd,
  output fixCtl_t          fixCtl,
  output logic [2:0]       eccStatus
);

  logic     synZero;
  logic     synInRange;
  logic     synPow2;
  eccStat_e statNow;

  assign synZero    = (syndrome == '0);
  assign synInRange = (32'(syndrome) <= MAX_POS);
  assign synPow2    = ((syndrome & (syndrome - 1'b1)) == '0);

  // Error locator and flag generator.
  always_comb begin
    fixCtl.flipData = 1'b0;
    fixCtl.flipPos  = PosW'(syndrome);
    if (!parityOdd) begin
      statNow = synZero ? ST_CLEAN : ST_UNFIX;
    end else if (synZero || synInRange) begin
      statNow         = ST_FIXED;
      fixCtl.flipData = !synZero && !synPow2;
    end else begin
      statNow = ST_UNFIX;
    end
  end

  if (REG_STATUS) begin : g_reg_stat
    logic [2:0] statQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statQ <= ST_CLEAN;
      else       statQ <= statNow;
    end
    assign eccStatus = statQ;
  end else begin : g_comb_stat
    assign eccStatus = statNow;
  end

  // R6: only the three legal codes ever appear.
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    eccStatus inside {3'b000, 3'b011, 3'b101});

  // R5: even overall parity never requests a flip.
  a_r5_even_no_flip: assert property (@(posedge clk) disable iff (!rstN)
    !parityOdd |-> !fixCtl.flipData);

  // R4: a check-bit position never requests a data flip.
  a_r4_check_no_flip: assert property (@(posedge clk) disable iff (!rstN)
    (synPow2 && !synZero) |-> !fixCtl.flipData);

  // R9: an unreachable syndrome never requests a flip.
  a_r9_oob_no_flip: assert property (@(posedge clk) disable iff (!rstN)
    !synInRange |-> !fixCtl.flipData);

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter  int DATA_W     = 64,
  parameter  bit REG_STATUS = 1'b1,
  localparam int HAM_W      = hamBits(DATA_W),
  localparam int CW_W       = DATA_W + HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CW_W-1:0]   encWord,
  input  logic [CW_W-1:0]   rdWord,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        eccStatus
);

  fixCtl_t          fixCtl;
  logic [HAM_W-1:0] syndrome;
  logic             parityOdd;

  secded_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrData   (wrData),
    .encWord  (encWord),
    .rdWord   (rdWord),
    .fixCtl   (fixCtl),
    .syndrome (syndrome),
    .parityOdd(parityOdd),
    .outData  (outData)
  );

  secded_ctrl #(.DATA_W(DATA_W), .REG_STATUS(REG_STATUS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syndrome (syndrome),
    .parityOdd(parityOdd),
    .fixCtl   (fixCtl),
    .eccStatus(eccStatus)
  );

endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] wrData = '0;
  logic [71:0] rdWord = '0;
  logic [71:0] encWord;
  logic [71:0] encWordC;
  logic [63:0] outData;
  logic [63:0] outDataC;
  logic [2:0]  statReg;
  logic [2:0]  statComb;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  secded_codec #(.REG_STATUS(1'b1)) u_secded_codec (
    .clk(clk), .rstN(rstN), .wrData(wrData), .encWord(encWord),
    .rdWord(rdWord), .outData(outData), .eccStatus(statReg));

  secded_codec #(.REG_STATUS(1'b0)) u_comb (
    .clk(clk), .rstN(rstN), .wrData(wrData), .encWord(encWordC),
    .rdWord(rdWord), .outData(outDataC), .eccStatus(statComb));

  // Independent reference encoder built from the R1 layout.
  function automatic logic [71:0] modelEnc(logic [63:0] d);
    logic [71:1] h;
    logic [6:0]  c;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        h[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int j = 0; j < 7; j++)
      for (int p = 1; p <= 71; p++)
        if (p[j]) c[j] = c[j] ^ h[p];
    return {^{c, d}, c, d};
  endfunction

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a read word on the falling edge, check the combinational
  // status at once, then the registered outputs one edge later.
  task automatic applyWord(logic [71:0] w, logic [63:0] expData,
                           logic [2:0] expStat, string req);
    @(negedge clk);
    rdWord = w;
    #1;
    chk(statComb == expStat, {req, " R7 comb status"}, 72'(statComb), 72'(expStat));
    @(negedge clk);
    chk(outData == expData, {req, " data"}, 72'(outData), 72'(expData));
    chk(statReg == expStat, {req, " status"}, 72'(statReg), 72'(expStat));
    chk(statReg inside {3'b000, 3'b011, 3'b101}, "R6 legal code",
        72'(statReg), 72'(expStat));
  endtask

  initial begin : watchdog
    #(8 * 150000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin : main
    logic [63:0] pats [4];
    logic [71:0] cw;
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hA5C3_0F96_5A3C_F069;
    pats[3] = 64'h0123_4567_89AB_CDEF;

    // R8: outputs cleared while reset is held.
    repeat (2) @(negedge clk);
    chk(outData == '0, "R8 reset data", 72'(outData), 72'h0);
    chk(statReg == 3'b000, "R8 reset status", 72'(statReg), 72'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int n = 0; n < 4; n++) begin
      wrData = pats[n];
      #1;
      cw = modelEnc(pats[n]);
      chk(encWord == cw, "R1 encode", encWord, cw);
      chk(^encWord == 1'b0, "R1 even parity", 72'(^encWord), 72'h0);
      applyWord(cw, pats[n], 3'b000, "R2 clean");
      for (int b = 0; b < 72; b++) begin
        if (b < 64) applyWord(cw ^ (72'd1 << b), pats[n], 3'b011, "R3 single data");
        else        applyWord(cw ^ (72'd1 << b), pats[n], 3'b011, "R4 single check");
      end
    end

    // R5: random bit pairs on random data.
    for (int t = 0; t < 200; t++) begin
      logic [63:0] d;
      logic [71:0] w;
      int b0;
      int b1;
      d  = {$urandom(), $urandom()};
      b0 = $urandom_range(71, 0);
      b1 = $urandom_range(71, 0);
      if (b1 == b0) b1 = (b0 + 1) % 72;
      w = modelEnc(d) ^ (72'd1 << b0) ^ (72'd1 << b1);
      applyWord(w, w[63:0], 3'b101, "R5 double");
    end

    // R9: check bits at positions 64, 8 and 2 give syndrome 74, odd parity.
    cw = modelEnc(pats[2]);
    cw = cw ^ (72'd1 << (64 + 6)) ^ (72'd1 << (64 + 3)) ^ (72'd1 << (64 + 1));
    applyWord(cw, cw[63:0], 3'b101, "R9 out of range");

    // R8: asynchronous clear in the middle of a cycle.
    applyWord(modelEnc(pats[1]) ^ 72'd1, pats[1], 3'b011, "R3 before clear");
    @(posedge clk);
    #2;
    rstN = 1'b0;
    #1;
    chk(outData == '0, "R8 async data", 72'(outData), 72'h0);
    chk(statReg == 3'b000, "R8 async status", 72'(statReg), 72'h0);
    @(negedge clk);
    rstN = 1'b1;
    applyWord(modelEnc(pats[3]), pats[3], 3'b000, "R2 after clear");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule